// File: doc/BRIEF.md
# Two-Phase Converter Interleaver

This block runs two identical 8-bit converter back ends as one channel at twice the rate of either. A single toggle register divides the fast master clock by two. Its two phases become complementary half-rate clocks, one for each converter, and the same phases become the output enables. Only one converter is therefore allowed onto the shared data bus in any master cycle, and ownership alternates every cycle.

Each converter reports its data, a flag saying that it is driving the shared bus, and its overrange bit. The block merges the two buses by their drive flags and combines the overrange bits with a logical OR, because the overrange outputs cannot share a wire. It captures the merged sample on the falling edge of the master clock. The result is one registered sample per master cycle, so the aggregate rate equals the master clock rate. A synchronous active-low reset parks the phase so that converter A owns the bus first after release.

Top module: `pingpong_interleaver`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, both enables are low and the falling edge that follows captures `smp_valid`=0, `smp_data`=8'h00 and `smp_ovr`=0, whatever the converter inputs are.
- R2: At the first rising edge with `rst_n` high, converter A is given the bus (`cnv_en`=2'b01). The following falling edge captures converter A's data with `smp_valid`=1.
- R3: Once running, the owner alternates every master cycle: `cnv_en` goes 2'b01 (A, bit 0) then 2'b10 (B, bit 1), and the two bits are never high together.
- R4: The converter clocks are complementary and each runs at half the master rate. While A owns the bus `cnv_clk`=2'b10, and while B owns it `cnv_clk`=2'b01 (bit 0 drives converter A, bit 1 drives converter B).
- R5: The outputs are loaded only on a falling edge of `clk`, from the values present just before that edge. A change to the converter inputs later in the low phase leaves them unchanged.
- R6: The captured sample is the data of whichever converter has its drive flag high, whether or not it is the scheduled owner. With neither drive flag high the sample is 8'h00.
- R7: `smp_ovr` is the OR of both converters' overrange bits, whatever the bus owner and the drive flags.
- R8: While running, `smp_valid` is high after every falling edge, giving one sample per master cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock at the aggregate sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cnv_a_data | input | 8 | Data output of converter A |
| cnv_a_drive | input | 1 | Converter A is driving the shared bus |
| cnv_a_ovr | input | 1 | Converter A overrange |
| cnv_b_data | input | 8 | Data output of converter B |
| cnv_b_drive | input | 1 | Converter B is driving the shared bus |
| cnv_b_ovr | input | 1 | Converter B overrange |
| cnv_clk | output | 2 | Half-rate clocks; bit 0 to A, bit 1 to B |
| cnv_en | output | 2 | Bus enables; bit 0 to A, bit 1 to B |
| smp_data | output | 8 | Registered interleaved sample |
| smp_ovr | output | 1 | Registered merged overrange |
| smp_valid | output | 1 | Sample strobe |

## Verification
Over 520 running cycles, converter A presents every code from 0 to 255 in its owned cycles while converter B presents the same codes in descending order. A stream that is swapped, stuck on one converter or shifted by one cycle therefore differs from the expected one. The two overrange bits follow unrelated periods, which separates an OR from an AND, from a bused overrange and from a selection by owner. Cycles with no drive flag, and cycles in which the non-owner drives, separate a merge by drive flag from a mux by owner. Inputs scrambled late in the low phase expose capture on the wrong edge. A mid-stream reset shows that the phase restarts with converter A.

// File: rtl/pingpong_pkg.sv
// Shared types for the two-phase converter interleaver.
package pingpong_pkg;
    // Which converter owns the shared bus in the current master cycle.
    typedef enum logic {
        OWNER_A = 1'b0,
        OWNER_B = 1'b1
    } owner_e;
endpackage

// File: rtl/pp_phase_gen.sv
// Phase generator: a single toggle register divides the master clock by two.
// Its two phases give both the converter clocks and the bus enables.
// Assumes a synchronous active-low reset, which holds ownership with A.
module pp_phase_gen
    import pingpong_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    output logic       run_o,
    output logic [1:0] cnv_clk_o,
    output logic [1:0] cnv_en_o
);
    owner_e owner_q;
    logic   run_q;

    // Toggle the owner each cycle once running; reset parks it on A.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            owner_q <= OWNER_A;
        end else begin
            run_q   <= 1'b1;
            owner_q <= run_q ? owner_e'(~owner_q) : OWNER_A;
        end
    end

    // Decode phases: complementary clocks and opposite-sense enables.
    always_comb begin
        cnv_clk_o[0] = (owner_q == OWNER_B);
        cnv_clk_o[1] = (owner_q == OWNER_A);
        cnv_en_o[0]  = (owner_q == OWNER_A) && run_q;
        cnv_en_o[1]  = (owner_q == OWNER_B);
        run_o        = run_q;
    end
endmodule

// File: rtl/pp_bus_merge.sv
// Bus merge: models the shared bus as an AND-OR of each converter's data
// qualified by its own drive flag. Overrange bits are ORed, never bused.
// Assumes the drive flags are mutually exclusive.
module pp_bus_merge #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_data,
    input  logic          a_drive,
    input  logic          a_ovr,
    input  logic [DW-1:0] b_data,
    input  logic          b_drive,
    input  logic          b_ovr,
    output logic [DW-1:0] bus_o,
    output logic          ovr_o
);
    // One bit slice of the shared bus per data bit.
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign bus_o[i] = (a_drive & a_data[i]) | (b_drive & b_data[i]);
    end

    // Combine the overrange flags with a logical OR.
    assign ovr_o = a_ovr | b_ovr;
endmodule

// File: rtl/pp_capture.sv
// Output stage: registers the merged bus on the falling master edge.
// Assumes run_i comes from a rising-edge register, so it is stable here.
// Clearing by run_i makes the reset synchronous on this edge too.
module pp_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          run_i,
    input  logic [DW-1:0] bus_i,
    input  logic          ovr_i,
    output logic [DW-1:0] data_o,
    output logic          ovr_o,
    output logic          valid_o
);
    // Capture one sample per master cycle, on the high-to-low transition.
    always_ff @(negedge clk) begin
        if (!run_i) begin
            data_o  <= '0;
            ovr_o   <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            data_o  <= bus_i;
            ovr_o   <= ovr_i;
            valid_o <= 1'b1;
        end
    end
endmodule

// File: rtl/pingpong_interleaver.sv
// Top level: interleaves two half-rate converters into one full-rate stream.
// Assumes the converters obey cnv_en and report their bus drive honestly.
module pingpong_interleaver #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] cnv_a_data,
    input  logic          cnv_a_drive,
    input  logic          cnv_a_ovr,
    input  logic [DW-1:0] cnv_b_data,
    input  logic          cnv_b_drive,
    input  logic          cnv_b_ovr,
    output logic [1:0]    cnv_clk,
    output logic [1:0]    cnv_en,
    output logic [DW-1:0] smp_data,
    output logic          smp_ovr,
    output logic          smp_valid
);
    logic          run;
    logic [DW-1:0] bus;
    logic          ovr_any;

    pp_phase_gen u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_o     (run),
        .cnv_clk_o (cnv_clk),
        .cnv_en_o  (cnv_en)
    );

    pp_bus_merge #(.DW(DW)) u_merge (
        .a_data  (cnv_a_data),
        .a_drive (cnv_a_drive),
        .a_ovr   (cnv_a_ovr),
        .b_data  (cnv_b_data),
        .b_drive (cnv_b_drive),
        .b_ovr   (cnv_b_ovr),
        .bus_o   (bus),
        .ovr_o   (ovr_any)
    );

    pp_capture #(.DW(DW)) u_cap (
        .clk     (clk),
        .run_i   (run),
        .bus_i   (bus),
        .ovr_i   (ovr_any),
        .data_o  (smp_data),
        .ovr_o   (smp_ovr),
        .valid_o (smp_valid)
    );
endmodule

// File: rtl/pp_checker.sv
// Property checker for the interleaver, attached by bind below.
module pp_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] cnv_a_data,
    input logic          cnv_a_drive,
    input logic          cnv_a_ovr,
    input logic [DW-1:0] cnv_b_data,
    input logic          cnv_b_drive,
    input logic          cnv_b_ovr,
    input logic [1:0]    cnv_clk,
    input logic [1:0]    cnv_en,
    input logic [DW-1:0] smp_data,
    input logic          smp_ovr,
    input logic          smp_valid
);
    // R3: never two owners, never two drivers.
    a_r3_en_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cnv_en));
    a_r3_drive_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnv_a_drive && cnv_b_drive));
    // R3: A hands over to B on the next cycle.
    a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_en == 2'b01) |=> (cnv_en == 2'b10));
    // R4: converter clocks change phase every master cycle while running.
    a_r4_clk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_en != 2'b00) |=> (cnv_clk != $past(cnv_clk)));
    // R6: a driving converter's data is what the falling edge captures.
    a_r6_data_a: assert property (@(negedge clk) disable iff (!rst_n)
        ((cnv_en != 2'b00) && cnv_a_drive) |=> (smp_data == $past(cnv_a_data)));
    // R7: overrange is the OR of both flags.
    a_r7_ovr_or: assert property (@(negedge clk) disable iff (!rst_n)
        (cnv_en != 2'b00) |=> (smp_ovr == ($past(cnv_a_ovr) | $past(cnv_b_ovr))));
    // R8: a strobe for every running cycle.
    a_r8_valid: assert property (@(negedge clk) disable iff (!rst_n)
        (cnv_en != 2'b00) |=> smp_valid);
endmodule

bind pingpong_interleaver pp_checker #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnv_a_data  (cnv_a_data),
    .cnv_a_drive (cnv_a_drive),
    .cnv_a_ovr   (cnv_a_ovr),
    .cnv_b_data  (cnv_b_data),
    .cnv_b_drive (cnv_b_drive),
    .cnv_b_ovr   (cnv_b_ovr),
    .cnv_clk     (cnv_clk),
    .cnv_en      (cnv_en),
    .smp_data    (smp_data),
    .smp_ovr     (smp_ovr),
    .smp_valid   (smp_valid)
);

// File: tb/sim_pingpong_interleaver.sv
module sim_pingpong_interleaver;
    localparam int PERIOD = 10;
    localparam int DW     = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] a_data, b_data;
    logic          a_drv, b_drv, a_ovr, b_ovr;
    logic [1:0]    cnv_clk, cnv_en;
    logic [DW-1:0] smp_data;
    logic          smp_ovr, smp_valid;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #(PERIOD/2) clk = ~clk;

    pingpong_interleaver #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cnv_a_data(a_data), .cnv_a_drive(a_drv), .cnv_a_ovr(a_ovr),
        .cnv_b_data(b_data), .cnv_b_drive(b_drv), .cnv_b_ovr(b_ovr),
        .cnv_clk(cnv_clk), .cnv_en(cnv_en),
        .smp_data(smp_data), .smp_ovr(smp_ovr), .smp_valid(smp_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Runs n cycles from reset release; c counts master cycles from 0.
    task automatic run_stream(input int n);
        rst_n = 1'b1;
        for (int c = 0; c < n; c++) begin
            bit idle, swap, sel;
            int ea, eb, ed;
            bit eo;
            @(posedge clk);
            #1;
            idle  = ((c % 64) == 20);
            swap  = ((c % 64) == 41);
            sel   = c[0];
            ea    = (c >> 1) & 255;
            eb    = 255 - ((c >> 1) & 255);
            a_data = ea[DW-1:0];
            b_data = eb[DW-1:0];
            a_ovr  = ((c % 3) == 0);
            b_ovr  = ((c % 5) == 1);
            eo     = a_ovr | b_ovr;
            a_drv  = idle ? 1'b0 : (swap ? cnv_en[1] : cnv_en[0]);
            b_drv  = idle ? 1'b0 : (swap ? cnv_en[0] : cnv_en[1]);
            if (idle) ed = 0;
            else      ed = ((sel ^ swap) != 0) ? eb : ea;
            @(negedge clk);
            #1;
            if (c == 0) chk("R2 first owner A", int'(cnv_en), 1);
            chk("R3 enable owner", int'(cnv_en), sel ? 2 : 1);
            chk("R4 converter clocks", int'(cnv_clk), sel ? 1 : 2);
            chk(idle ? "R6 no driver" : (swap ? "R6 non-owner drives" : "R2 R6 data"),
                int'(smp_data), ed);
            chk("R7 overrange OR", int'(smp_ovr), int'(eo));
            chk("R8 valid", int'(smp_valid), 1);
            // R5: scramble inputs late in the low phase; outputs must hold.
            #2;
            a_data = ~a_data; b_data = ~b_data; a_ovr = ~a_ovr; b_ovr = ~b_ovr;
            #1;
            chk("R5 data held", int'(smp_data), ed);
            chk("R5 ovr held", int'(smp_ovr), int'(eo));
        end
    endtask

    initial begin
        rst_n = 1'b0;
        a_data = 8'hA5; b_data = 8'h5A;
        a_drv = 1'b1; b_drv = 1'b0; a_ovr = 1'b1; b_ovr = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 reset valid", int'(smp_valid), 0);
        chk("R1 reset data", int'(smp_data), 0);
        chk("R1 reset ovr", int'(smp_ovr), 0);
        chk("R1 reset enables", int'(cnv_en), 0);
        run_stream(520);
        // Mid-stream reset, then restart with converter A.
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        a_drv = 1'b0; b_drv = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 re-reset valid", int'(smp_valid), 0);
        chk("R1 re-reset enables", int'(cnv_en), 0);
        chk("R1 re-reset data", int'(smp_data), 0);
        run_stream(40);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule